// File: doc/BRIEF.md
# MDIO Management Master

This block runs PHY register accesses over the two-wire station management bus. The bus has a clock line (MDC) that only this master drives, and one shared data line (MDIO). A host pulses a start strobe along with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The master then runs the whole frame by itself. It sends a run of 32 clock pulses with the data line held high, then the start code, the opcode and both addresses. After that it either keeps driving a turnaround pattern and the write data, or it hands the line to the PHY and shifts in 16 bits.

On a read, the line level seen just after the turnaround pulse tells the master whether a PHY answered. A high level there means the line was left to its pull-up. In that case the access is flagged as an error and the returned data is forced to zero. The data line only changes, and only changes direction, while MDC is low. When the frame ends, the master takes the line back without an extra clock edge and pulses a one-cycle done strobe that carries the read data and the error flag.

The MDC half period is a parameter, counted in system clock cycles. The default gives a 400 ns MDC period from a 100 MHz clock.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, busy_o, done_o and mdc_o are 0, mdio_oe_o is 1 and mdio_o is 1, and they stay this way until a start strobe is accepted.
- R2: Every frame opens with 32 MDC rising edges, and at each of them mdio_o is 1 and mdio_oe_o is 1.
- R3: The next 14 rising edges carry, MSB first, the start code 01, the opcode (10 for read when wr_i=0, 01 for write when wr_i=1), the PHY address and then the register address. mdio_o and mdio_oe_o do not change on the cycle in which MDC rises.
- R4: In a write frame, the next 18 rising edges carry the turnaround pattern 10 and then wdata_i MSB first. mdio_oe_o stays 1 for the whole frame, and the done strobe reports rdata_o=0 and err_o=0.
- R5: Every frame has exactly 64 MDC rising edges. In a read frame, mdio_oe_o goes to 0 only while MDC is low, right after the 46th rising edge, and stays 0 for the last 18 rising edges.
- R6: In a read frame, mdio_i is sampled at the end of the low half before each of the last 16 rising edges. The samples are assembled MSB first into rdata_o when no error was flagged.
- R7: In a read frame, mdio_i is sampled at the end of the low half that follows the turnaround pulse (the 47th pulse). A high level there sets err_o and forces rdata_o to 0.
- R8: When a frame ends, done_o is high for exactly one cycle. busy_o falls in that same cycle, and mdio_oe_o returns to 1 with mdc_o low and no further MDC edge.
- R9: A start strobe that arrives while busy_o is 1 is ignored. It does not change the frame in progress and no frame follows it.
- R10: Each MDC low half and high half lasts exactly MDC_HALF system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| wr_i | input | 1 | 1 = register write, 0 = register read |
| phy_i | input | 5 | PHY address |
| reg_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 16 | Read result, valid with done_o |
| err_o | output | 1 | No PHY answered the read, valid with done_o |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driving |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen on the pad |

## Verification
Nearly all of the sequencer state shows up directly on the bus. A wrong slot count or a stuck phase changes the number of MDC edges in a frame, or shifts where mdio_oe_o falls, and this becomes visible within one MDC period of the fault. A corrupted frame shift register puts a wrong bit on mdio_o at the very next rising edge. A fault in the sample timing or in the error latch is hidden until the done strobe, where rdata_o or err_o disagrees with the data the bench's PHY model returned. A broken half-period counter stretches the first MDC half that follows it.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
    localparam int PHY_AW    = 5;
    localparam int REG_AW    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int CODE_W    = 2;
    localparam int HDR_LEN   = 2 * CODE_W + PHY_AW + REG_AW;
    localparam int TA_LEN    = 2;
    localparam int FRAME_LEN = PRE_LEN + HDR_LEN + TA_LEN + DATA_W;
    localparam int SLOT_W    = $clog2(FRAME_LEN);
    localparam int TA_SLOT   = PRE_LEN + HDR_LEN;
    localparam int ERR_SLOT  = TA_SLOT + 1;

    localparam logic [CODE_W-1:0] SOF_CODE = 2'b01;
    localparam logic [CODE_W-1:0] OP_READ  = 2'b10;
    localparam logic [CODE_W-1:0] OP_WRITE = 2'b01;
    localparam logic [TA_LEN-1:0] TA_DRIVE = 2'b10;

    typedef struct packed {
        logic                 busy;
        logic                 rd;
        logic                 phase;
        logic [SLOT_W-1:0]    slot;
        logic [FRAME_LEN-1:0] frame;
        logic [DATA_W-1:0]    rx;
        logic                 err;
        logic                 done;
        logic [DATA_W-1:0]    rdata;
        logic                 rerr;
    } seq_t;
endpackage

// File: rtl/mdio_half_timer.sv
`timescale 1ns/1ps
module mdio_half_timer #(
    parameter int HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/mdio_frame_pack.sv
`timescale 1ns/1ps
module mdio_frame_pack
    import mdio_mgmt_pkg::*;
(
    input  logic                 wr,
    input  logic [PHY_AW-1:0]    phy,
    input  logic [REG_AW-1:0]    regad,
    input  logic [DATA_W-1:0]    wdata,
    output logic [FRAME_LEN-1:0] frame
);
    logic [CODE_W-1:0] op;
    logic [TA_LEN-1:0] ta;
    logic [DATA_W-1:0] tail;

    always_comb begin
        op    = wr ? OP_WRITE : OP_READ;
        ta    = wr ? TA_DRIVE : {TA_LEN{1'b1}};
        tail  = wr ? wdata : {DATA_W{1'b1}};
        frame = {{PRE_LEN{1'b1}}, SOF_CODE, op, phy, regad, ta, tail};
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int MDC_HALF = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic [PHY_AW-1:0] phy_i,
    input  logic [REG_AW-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    localparam logic [SLOT_W-1:0] TA_S   = SLOT_W'(TA_SLOT);
    localparam logic [SLOT_W-1:0] ERR_S  = SLOT_W'(ERR_SLOT);
    localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(FRAME_LEN - 1);

    seq_t                 q, d;
    logic                 tick;
    logic [FRAME_LEN-1:0] frame_w;

    mdio_half_timer #(.HALF(MDC_HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.busy),
        .tick  (tick)
    );

    mdio_frame_pack u_pack (
        .wr    (wr_i),
        .phy   (phy_i),
        .regad (reg_i),
        .wdata (wdata_i),
        .frame (frame_w)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy  = 1'b1;
                d.rd    = !wr_i;
                d.phase = 1'b0;
                d.slot  = '0;
                d.frame = frame_w;
                d.rx    = '0;
                d.err   = 1'b0;
            end
        end else if (tick) begin
            if (!q.phase) begin
                // end of low half: read-side sampling just before MDC rises
                if (q.rd && q.slot == ERR_S) begin
                    d.err = mdio_i;
                end else if (q.rd && q.slot > ERR_S) begin
                    d.rx = {q.rx[DATA_W-2:0], mdio_i};
                end
                d.phase = 1'b1;
            end else begin
                // end of high half: MDC falls, next bit goes out
                d.phase = 1'b0;
                d.frame = {q.frame[FRAME_LEN-2:0], 1'b1};
                if (q.slot == LAST_S) begin
                    d.busy  = 1'b0;
                    d.done  = 1'b1;
                    d.rerr  = q.rd && q.err;
                    d.rdata = (q.rd && !q.err) ? q.rx : '0;
                end else begin
                    d.slot = q.slot + SLOT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = q.busy;
    assign done_o    = q.done;
    assign rdata_o   = q.rdata;
    assign err_o     = q.rerr;
    assign mdc_o     = q.phase;
    assign mdio_o    = q.busy ? q.frame[FRAME_LEN-1] : 1'b1;
    assign mdio_oe_o = !(q.busy && q.rd && q.slot >= TA_S);
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_master_chk #(
    parameter int HALF = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic [15:0] rdata_o,
    input logic        mdc_o,
    input logic        mdio_o,
    input logic        mdio_oe_o
);
    logic        mdc_prev;
    logic [31:0] hcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_prev <= 1'b0;
            hcnt     <= '0;
        end else begin
            mdc_prev <= mdc_o;
            if (mdc_o != mdc_prev) begin
                hcnt <= 32'd1;
            end else if (!busy_o) begin
                hcnt <= '0;
            end else begin
                hcnt <= hcnt + 32'd1;
            end
        end
    end

    // R1 and R8: an idle master drives the line high with MDC low
    a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && mdio_oe_o && mdio_o));

    a_r3_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    a_r5_dir_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe_o != $past(mdio_oe_o)) |-> !mdc_o);

    a_r8_done_one: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && mdio_oe_o && !mdc_o));

    a_r8_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (rdata_o == 16'h0000));

    a_r10_half_len: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mdc_o != mdc_prev) |-> (hcnt == 32'(HALF)));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.HALF(MDC_HALF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .rdata_o   (rdata_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;
    localparam int HALF = 20;

    typedef struct {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wdata;
        logic        present;
        logic [15:0] word;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [4:0]  phy_i = '0;
    logic [4:0]  reg_i = '0;
    logic [15:0] wdata_i = '0;
    logic        busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rdata_o;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    item_t sb_q[$];
    logic        phy_present = 1'b0;
    logic [15:0] phy_word = '0;

    mdio_mgmt_master #(.MDC_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
        .phy_i(phy_i), .reg_i(reg_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .err_o(err_o),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: bus capture, PHY model and scoreboard compare
    logic [63:0] cap_bit = '0;
    logic [63:0] cap_oe = '0;
    int          edge_cnt = 0;
    int          rise0 = 0;
    int          rise1 = 0;
    logic        mdc_prev = 1'b0;

    always @(negedge clk) begin
        if (mdc_o && !mdc_prev) begin
            if (edge_cnt < 64) begin
                cap_bit[63-edge_cnt] = mdio_o;
                cap_oe[63-edge_cnt]  = mdio_oe_o;
            end
            if (edge_cnt == 0) rise0 = cyc;
            if (edge_cnt == 1) rise1 = cyc;
            edge_cnt++;
        end
        if (!mdc_o && mdc_prev) begin
            if (mdio_oe_o || !phy_present) mdio_i = 1'b1;
            else if (edge_cnt == 47) mdio_i = 1'b0;
            else if (edge_cnt >= 48 && edge_cnt <= 63) mdio_i = phy_word[63-edge_cnt];
            else mdio_i = 1'b1;
        end
        mdc_prev = mdc_o;
        if (done_o) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 64'(edge_cnt), 64'd0);
            end else begin
                item_t it;
                logic [63:0] exp;
                it  = sb_q.pop_front();
                exp = {32'hFFFF_FFFF, 2'b01, (it.wr ? 2'b01 : 2'b10), it.phy, it.rg, 2'b10, it.wdata};
                chk(cap_bit[63:32] == 32'hFFFF_FFFF && cap_oe[63:32] == 32'hFFFF_FFFF,
                    "R2 preamble", cap_bit, exp);
                chk(cap_bit[31:18] == exp[31:18] && cap_oe[31:18] == 14'h3FFF,
                    "R3 header", 64'(cap_bit[31:18]), 64'(exp[31:18]));
                chk(edge_cnt == 64, "R5 edge count", 64'(edge_cnt), 64'd64);
                chk(rise1 - rise0 == 2 * HALF, "R10 mdc period", 64'(rise1 - rise0), 64'(2 * HALF));
                if (it.wr) begin
                    chk(cap_bit[17:0] == exp[17:0] && cap_oe == '1,
                        "R4 write tail", 64'(cap_bit[17:0]), 64'(exp[17:0]));
                    chk(rdata_o == 16'h0 && !err_o, "R4 write result", {47'd0, err_o, rdata_o}, 64'd0);
                end else begin
                    chk(cap_oe == {{46{1'b1}}, 18'd0}, "R5 read direction", cap_oe, {{46{1'b1}}, 18'd0});
                    if (it.present)
                        chk(rdata_o == it.word && !err_o, "R6 read data",
                            {47'd0, err_o, rdata_o}, {48'd0, it.word});
                    else
                        chk(rdata_o == 16'h0 && err_o, "R7 absent phy",
                            {47'd0, err_o, rdata_o}, {47'd0, 1'b1, 16'h0});
                end
            end
            edge_cnt = 0;
            cap_bit  = '0;
            cap_oe   = '0;
        end
    end

    task automatic run_txn(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic present, input logic [15:0] word,
                           input bit inject);
        item_t it;
        it.wr = wr; it.phy = phy; it.rg = rg; it.wdata = wd;
        it.present = present; it.word = word;
        while (busy_o) @(negedge clk);
        phy_present = present;
        phy_word    = word;
        sb_q.push_back(it);
        @(negedge clk);
        start_i = 1'b1; wr_i = wr; phy_i = phy; reg_i = rg; wdata_i = wd;
        @(negedge clk);
        start_i = 1'b0;
        if (inject) begin
            repeat (300) @(negedge clk);
            start_i = 1'b1; wr_i = !wr; phy_i = ~phy; reg_i = ~rg; wdata_i = ~wd;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
        chk(!done_o && !busy_o && mdio_oe_o && !mdc_o, "R8 end of frame",
            {60'd0, done_o, busy_o, mdio_oe_o, mdc_o}, 64'h2);
        if (inject) begin
            repeat (4 * HALF) @(negedge clk);
            chk(!busy_o && !mdc_o && sb_q.size() == 0, "R9 no follow-on frame",
                {62'd0, busy_o, mdc_o}, 64'd0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !mdc_o && mdio_oe_o && mdio_o, "R1 reset state",
            {59'd0, busy_o, done_o, mdc_o, mdio_oe_o, mdio_o}, 64'h3);
        run_txn(1'b1, 5'h01, 5'h00, 16'h1234, 1'b1, 16'h0000, 1'b0);
        run_txn(1'b0, 5'h1F, 5'h1F, 16'h0000, 1'b1, 16'hA5C3, 1'b0);
        run_txn(1'b0, 5'h07, 5'h02, 16'h0000, 1'b0, 16'hFFFF, 1'b0);
        run_txn(1'b1, 5'h15, 5'h0A, 16'hFFFF, 1'b0, 16'h0000, 1'b0);
        run_txn(1'b1, 5'h0A, 5'h15, 16'h0000, 1'b1, 16'h0000, 1'b0);
        run_txn(1'b0, 5'h10, 5'h01, 16'h0000, 1'b1, 16'h8001, 1'b0);
        run_txn(1'b0, 5'h03, 5'h11, 16'h0000, 1'b1, 16'h0000, 1'b0);
        run_txn(1'b0, 5'h05, 5'h06, 16'h0000, 1'b1, 16'h3C5A, 1'b1);
        run_txn(1'b1, 5'h12, 5'h04, 16'hBEEF, 1'b1, 16'h0000, 1'b1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule